// File: doc/BRIEF.md
# Qualified Hardware Event Counter

This block is one slice of a performance-monitoring unit. Every clock it receives a small per-cycle event count (an occupancy-style value that saturates at 15), the privilege level the processor is running at, and one activity bit per logical processor. A configuration word sets which privilege levels count, which pattern of processor activity counts, and whether the count is compared against a threshold (optionally inverted and optionally reduced to rising edges). The resulting increment is added to a wide accumulator that software can load and observe.

When the accumulator wraps, the slice emits a single-cycle overflow pulse. That pulse is meant to be wired to the cascade input of a partner slice, which in cascade mode counts its partner's wraps instead of its own events. A sticky interrupt flag records a wrap when interrupts are enabled. The event input is sampled on every clock with no back-pressure: an occupancy count describes the current cycle and cannot be held, so the block has no valid/ready pair. All other pins are plain control and status.

Top module: `evt_counter_slice`

## Requirements
- R1: After reset the counter reads zero, the overflow pulse and the interrupt flag are low, and the configuration is all zero except the activity selector, which holds "all active" (code 2). With both privilege enables clear, every privilege level counts.
- R2: With the threshold disabled and cascade off, each qualifying cycle adds the raw 4-bit event count to the counter.
- R3: Configuration bit 0 enables counting at privilege level 0, bit 1 enables counting at levels 1, 2 and 3; when both bits are clear, all levels count.
- R4: Configuration bits [3:2] select the activity filter over the active bits: 0 counts when no processor is active, 1 when exactly one is, 2 when all are, 3 when at least one is.
- R5: With the threshold enable (bit 4) set and complement (bit 5) clear, a qualifying cycle adds exactly 1 when the event count is strictly greater than the threshold held in bits [12:9], and 0 otherwise.
- R6: With threshold and complement both set, a qualifying cycle adds exactly 1 when the event count is strictly less than the threshold; an equal count never adds.
- R7: With edge mode (bit 6) and threshold both set, 1 is added only in a cycle whose qualified compare result is true after a false one; a configuration write clears this history. Edge mode without threshold has no effect.
- R8: With cascade (bit 7) set, the counter adds 1 in each cycle the cascade input is high and ignores its own event, privilege and activity inputs.
- R9: A counter write loads the written value in the next cycle, takes priority over any increment in the same cycle, suppresses overflow for that cycle and clears the interrupt flag.
- R10: When an increment carries out of the counter's top bit, the overflow output is high for exactly the one cycle in which the counter shows the wrapped value.
- R11: A wrap sets the interrupt flag only when the interrupt enable (bit 8) is set; once set, the flag stays high until a counter write.
- R12: A configuration write takes effect from the following cycle; the cycle of the write itself is counted under the previous configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_cnt | input | EVT_W (4) | Per-cycle event count |
| priv_lvl | input | 2 | Current privilege level, 0 is most privileged |
| lp_active | input | NUM_LP (2) | One activity bit per logical processor |
| casc_in | input | 1 | Overflow pulse from the partner slice |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9+EVT_W (13) | Configuration word |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W (40) | Value to load into the counter |
| cnt_value | output | CNT_W (40) | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse on counter wrap |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The raw-add path is swept over every event count, and every pairing of privilege enables with privilege level and every activity selector with every activity pattern, so that a wrongly decoded level or selector shows up as a missing or extra add. The threshold path is swept over all 256 pairs of threshold and event count in both polarities; the equal-value diagonal tells strict from non-strict compares. Edge mode is driven with runs of true and false compare results and a configuration rewrite in mid-run, which separates edge counting from level counting and shows whether the history clears. Loads just below the top value, with and without a coincident write or interrupt enable, tell wrap, pulse width, write priority and flag stickiness apart.

// File: rtl/ecs_pkg.sv
`timescale 1ns/1ps
package ecs_pkg;

  // Activity filter codes
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ONE  = 2'd1,
    ACT_ALL  = 2'd2,
    ACT_ANY  = 2'd3
  } act_sel_e;

  // Configuration word bit positions; threshold field sits on top
  localparam int B_KERN    = 0;
  localparam int B_USER    = 1;
  localparam int B_ACT_LO  = 2;
  localparam int B_THR_EN  = 4;
  localparam int B_COMPL   = 5;
  localparam int B_EDGE    = 6;
  localparam int B_CASC    = 7;
  localparam int B_IRQ_EN  = 8;
  localparam int B_THR_LO  = 9;
  localparam int CFG_FIXED_W = 9;

endpackage

// File: rtl/ecs_cfg_reg.sv
`timescale 1ns/1ps
module ecs_cfg_reg #(
  parameter int EVT_W = 4,
  localparam int CFG_W = ecs_pkg::CFG_FIXED_W + EVT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             kern_en,
  output logic             user_en,
  output ecs_pkg::act_sel_e act_sel,
  output logic             thr_en,
  output logic             compl_en,
  output logic             edge_en,
  output logic             casc_en,
  output logic             irq_en,
  output logic [EVT_W-1:0] thr_val
);
  import ecs_pkg::*;

  localparam logic [CFG_W-1:0] CFG_RST =
    CFG_W'(ACT_ALL) << B_ACT_LO;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_comb begin
    kern_en  = cfg_q[B_KERN];
    user_en  = cfg_q[B_USER];
    act_sel  = act_sel_e'(cfg_q[B_ACT_LO +: 2]);
    thr_en   = cfg_q[B_THR_EN];
    compl_en = cfg_q[B_COMPL];
    edge_en  = cfg_q[B_EDGE];
    casc_en  = cfg_q[B_CASC];
    irq_en   = cfg_q[B_IRQ_EN];
    thr_val  = cfg_q[B_THR_LO +: EVT_W];
  end

endmodule

// File: rtl/ecs_qualify.sv
`timescale 1ns/1ps
module ecs_qualify #(
  parameter int NUM_LP = 2,
  localparam int CNT_LP_W = $clog2(NUM_LP + 1)
) (
  input  logic [1:0]        priv_lvl,
  input  logic [NUM_LP-1:0] lp_active,
  input  logic              kern_en,
  input  logic              user_en,
  input  ecs_pkg::act_sel_e act_sel,
  output logic              qual_ok
);
  import ecs_pkg::*;

  // Population count of active logical processors, built as a chain
  logic [CNT_LP_W-1:0] pop [NUM_LP+1];
  assign pop[0] = '0;
  for (genvar g = 0; g < NUM_LP; g++) begin : g_pop
    assign pop[g+1] = pop[g] + CNT_LP_W'(lp_active[g]);
  end

  logic priv_ok;
  logic act_ok;

  always_comb begin
    if (!kern_en && !user_en) priv_ok = 1'b1;
    else if (priv_lvl == 2'd0) priv_ok = kern_en;
    else                       priv_ok = user_en;
  end

  always_comb begin
    unique case (act_sel)
      ACT_NONE: act_ok = (pop[NUM_LP] == '0);
      ACT_ONE:  act_ok = (pop[NUM_LP] == CNT_LP_W'(1));
      ACT_ALL:  act_ok = (pop[NUM_LP] == CNT_LP_W'(NUM_LP));
      default:  act_ok = (pop[NUM_LP] != '0);
    endcase
  end

  assign qual_ok = priv_ok && act_ok;

endmodule

// File: rtl/ecs_thresh.sv
`timescale 1ns/1ps
module ecs_thresh #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_cnt,
  input  logic             qual_ok,
  input  logic             thr_en,
  input  logic             compl_en,
  input  logic             edge_en,
  input  logic [EVT_W-1:0] thr_val,
  input  logic             cfg_we,
  output logic [EVT_W-1:0] step
);
  logic cmp;
  logic hit;
  logic hist_q;
  logic fire;

  assign cmp = compl_en ? (evt_cnt < thr_val) : (evt_cnt > thr_val);
  assign hit = qual_ok && cmp;

  // Previous qualified compare result; dropped on any config write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hist_q <= 1'b0;
    else if (cfg_we) hist_q <= 1'b0;
    else             hist_q <= hit;
  end

  assign fire = edge_en ? (hit && !hist_q) : hit;

  always_comb begin
    if (thr_en)       step = EVT_W'(fire);
    else if (qual_ok) step = evt_cnt;
    else              step = '0;
  end

endmodule

// File: rtl/ecs_accum.sv
`timescale 1ns/1ps
module ecs_accum #(
  parameter int CNT_W = 40,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] step,
  input  logic             casc_en,
  input  logic             casc_in,
  input  logic             irq_en,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q,
  output logic             irq_q
);
  logic [EVT_W-1:0] inc;
  logic [CNT_W:0]   sum;

  assign inc = casc_en ? EVT_W'(casc_in) : step;
  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (cnt_we) begin
      cnt_q <= cnt_wdata;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= sum[CNT_W-1:0];
      ovf_q <= sum[CNT_W];
      irq_q <= irq_q | (sum[CNT_W] & irq_en);
    end
  end

endmodule

// File: rtl/evt_counter_slice.sv
`timescale 1ns/1ps
module evt_counter_slice #(
  parameter int CNT_W  = 40,
  parameter int EVT_W  = 4,
  parameter int NUM_LP = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [EVT_W-1:0]                    evt_cnt,
  input  logic [1:0]                          priv_lvl,
  input  logic [NUM_LP-1:0]                   lp_active,
  input  logic                                casc_in,
  input  logic                                cfg_we,
  input  logic [ecs_pkg::CFG_FIXED_W+EVT_W-1:0] cfg_wdata,
  input  logic                                cnt_we,
  input  logic [CNT_W-1:0]                    cnt_wdata,
  output logic [CNT_W-1:0]                    cnt_value,
  output logic                                ovf_pulse,
  output logic                                irq
);
  logic              kern_en, user_en, thr_en, compl_en, edge_en;
  logic              casc_mode, irq_en, qual_ok;
  ecs_pkg::act_sel_e act_sel;
  logic [EVT_W-1:0]  thr_val;
  logic [EVT_W-1:0]  step;

  ecs_cfg_reg #(.EVT_W(EVT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .kern_en(kern_en), .user_en(user_en), .act_sel(act_sel),
    .thr_en(thr_en), .compl_en(compl_en), .edge_en(edge_en),
    .casc_en(casc_mode), .irq_en(irq_en), .thr_val(thr_val)
  );

  ecs_qualify #(.NUM_LP(NUM_LP)) u_qual (
    .priv_lvl(priv_lvl), .lp_active(lp_active), .kern_en(kern_en),
    .user_en(user_en), .act_sel(act_sel), .qual_ok(qual_ok)
  );

  ecs_thresh #(.EVT_W(EVT_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .qual_ok(qual_ok),
    .thr_en(thr_en), .compl_en(compl_en), .edge_en(edge_en),
    .thr_val(thr_val), .cfg_we(cfg_we), .step(step)
  );

  ecs_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(step), .casc_en(casc_mode),
    .casc_in(casc_in), .irq_en(irq_en), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cnt_q(cnt_value), .ovf_q(ovf_pulse),
    .irq_q(irq)
  );

endmodule

// File: rtl/ecs_checker.sv
`timescale 1ns/1ps
module ecs_checker #(
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             casc_in,
  input logic             casc_mode,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_value,
  input logic             ovf_pulse,
  input logic             irq
);
  // R9: a write lands next cycle regardless of increments
  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_value == $past(cnt_wdata)) && !ovf_pulse && !irq);

  // R10: overflow is a single-cycle pulse
  a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  // R10: after a wrap the counter holds only the carried-over remainder
  a_r10_wrapped_small: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (cnt_value < CNT_W'(16)));

  // R2: without a write or wrap the counter never steps by more than 15
  a_r2_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> ovf_pulse || ((cnt_value - $past(cnt_value)) <= CNT_W'(15)));

  // R11: the flag only rises together with an overflow
  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ovf_pulse);

  // R11: the flag is sticky until a counter write
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cnt_we) |=> irq);

  // R8: in cascade mode a quiet partner leaves the counter unchanged
  a_r8_casc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_mode && !casc_in && !cnt_we) |=> $stable(cnt_value));

endmodule

bind evt_counter_slice ecs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .casc_in(casc_in), .casc_mode(casc_mode),
  .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_value(cnt_value),
  .ovf_pulse(ovf_pulse), .irq(irq)
);

// File: tb/evt_counter_slice_bench.sv
`timescale 1ns/1ps
module evt_counter_slice_bench;
  localparam int CNT_W = 40;
  localparam int EVT_W = 4;
  localparam int CFG_W = 13;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [EVT_W-1:0] evt_cnt = '0;
  logic [1:0]       priv_lvl = '0;
  logic [1:0]       lp_active = '0;
  logic             casc_in = 1'b0;
  logic             cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             cnt_we = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic [CNT_W-1:0] cnt_value;
  logic             ovf_pulse;
  logic             irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Independent model state
  logic [CNT_W-1:0] m_cnt = '0;
  logic             m_ovf = 1'b0;
  logic             m_irq = 1'b0;
  logic             m_hist = 1'b0;
  logic [CFG_W-1:0] m_cfg = 13'h008;

  always #2.5 clk = ~clk;

  evt_counter_slice #(.CNT_W(CNT_W), .EVT_W(EVT_W), .NUM_LP(2)) u_evt_counter_slice (
    .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .priv_lvl(priv_lvl),
    .lp_active(lp_active), .casc_in(casc_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cnt_value(cnt_value), .ovf_pulse(ovf_pulse), .irq(irq)
  );

  function automatic logic [CFG_W-1:0] mk(input bit k, input bit u,
      input logic [1:0] sel, input bit te, input logic [3:0] tv,
      input bit cm, input bit ed, input bit cs, input bit ie);
    return {tv, ie, cs, ed, cm, te, sel, u, k};
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (cnt_value !== m_cnt || ovf_pulse !== m_ovf || irq !== m_irq) begin
      failures++;
      $display("FAIL %s: actual cnt=%h ovf=%b irq=%b expected cnt=%h ovf=%b irq=%b",
               tag, cnt_value, ovf_pulse, irq, m_cnt, m_ovf, m_irq);
    end
  endtask

  // One clock: drive at the falling edge, model, check after the rising edge
  task automatic cyc(input logic [3:0] e, input logic [1:0] pl,
      input logic [1:0] act, input bit cin, input bit cwe,
      input logic [CFG_W-1:0] cdat, input bit nwe,
      input logic [CNT_W-1:0] ndat, input string tag);
    bit k, u, te, cm, ed, cs, ie, po, ao, q, c, f;
    logic [1:0] sel;
    logic [3:0] tv, inc;
    logic [CNT_W:0] sum;
    int ones;
    @(negedge clk);
    evt_cnt = e; priv_lvl = pl; lp_active = act; casc_in = cin;
    cfg_we = cwe; cfg_wdata = cdat; cnt_we = nwe; cnt_wdata = ndat;
    k = m_cfg[0]; u = m_cfg[1]; sel = m_cfg[3:2]; te = m_cfg[4];
    cm = m_cfg[5]; ed = m_cfg[6]; cs = m_cfg[7]; ie = m_cfg[8];
    tv = m_cfg[12:9];
    po = (!k && !u) || (pl == 2'd0 ? k : u);
    ones = int'(act[0]) + int'(act[1]);
    case (sel)
      2'd0: ao = (ones == 0);
      2'd1: ao = (ones == 1);
      2'd2: ao = (ones == 2);
      default: ao = (ones >= 1);
    endcase
    q = po && ao;
    c = q && (cm ? (e < tv) : (e > tv));
    f = ed ? (c && !m_hist) : c;
    if (cs)      inc = {3'b0, cin};
    else if (te) inc = {3'b0, f};
    else         inc = q ? e : 4'd0;
    sum = {1'b0, m_cnt} + {37'b0, inc};
    if (nwe) begin
      m_cnt = ndat; m_ovf = 1'b0; m_irq = 1'b0;
    end else begin
      m_cnt = sum[CNT_W-1:0]; m_ovf = sum[CNT_W];
      m_irq = m_irq | (sum[CNT_W] & ie);
    end
    m_hist = cwe ? 1'b0 : c;
    if (cwe) m_cfg = cdat;
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic ev(input logic [3:0] e, input logic [1:0] pl,
      input logic [1:0] act, input string tag);
    cyc(e, pl, act, 1'b0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  task automatic wcfg(input logic [CFG_W-1:0] d, input string tag);
    cyc(4'd0, 2'd0, 2'b00, 1'b0, 1'b1, d, 1'b0, '0, tag);
  endtask

  task automatic wcnt(input logic [CNT_W-1:0] d, input string tag);
    cyc(4'd0, 2'd0, 2'b00, 1'b0, 1'b0, '0, 1'b1, d, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: default config counts at any level only with all processors active
    ev(4'd3, 2'd0, 2'b11, "R1 default both-active counts");
    ev(4'd5, 2'd2, 2'b11, "R1 default user level counts");
    ev(4'd6, 2'd1, 2'b01, "R1 default one-active blocked");

    // R2: raw add of every event count
    for (int e = 0; e < 16; e++) ev(4'(e), 2'd3, 2'b11, "R2 raw add");

    // R3: privilege enable pairs against every level
    for (int pe = 0; pe < 4; pe++) begin
      wcfg(mk(pe[0], pe[1], 2'd2, 0, 0, 0, 0, 0, 0), "R12 cfg write");
      for (int pl = 0; pl < 4; pl++)
        ev(4'(pl + 1), 2'(pl), 2'b11, "R3 privilege filter");
    end

    // R4: every selector against every activity pattern
    for (int s = 0; s < 4; s++) begin
      wcfg(mk(0, 0, 2'(s), 0, 0, 0, 0, 0, 0), "R12 cfg write");
      for (int a = 0; a < 4; a++) ev(4'd7, 2'd1, 2'(a), "R4 activity filter");
    end

    // R5 / R6: full threshold sweep in both polarities
    for (int cm = 0; cm < 2; cm++)
      for (int tv = 0; tv < 16; tv++) begin
        wcfg(mk(0, 0, 2'd3, 1, 4'(tv), cm[0], 0, 0, 0), "R12 cfg write");
        for (int e = 0; e < 16; e++)
          ev(4'(e), 2'd0, 2'b01, cm ? "R6 complement compare" : "R5 threshold compare");
      end

    // R5: threshold qualified by privilege gating
    wcfg(mk(1, 0, 2'd3, 1, 4'd2, 0, 0, 0, 0), "R12 cfg write");
    ev(4'd9, 2'd2, 2'b01, "R5 threshold gated by privilege");
    ev(4'd9, 2'd0, 2'b01, "R5 threshold passes at level 0");

    // R7: edge detection on threshold compare
    wcfg(mk(0, 0, 2'd3, 1, 4'd5, 0, 1, 0, 0), "R12 cfg write");
    begin
      logic [3:0] pat [12] = '{6, 7, 2, 9, 9, 9, 1, 8, 3, 3, 15, 15};
      foreach (pat[i]) ev(pat[i], 2'd0, 2'b10, "R7 edge counting");
    end
    // rewrite mid-run: history cleared, held-high compare counts again
    cyc(4'd9, 2'd0, 2'b10, 1'b0, 1'b1, mk(0, 0, 2'd3, 1, 4'd5, 0, 1, 0, 0),
        1'b0, '0, "R7 cfg write during high run");
    ev(4'd9, 2'd0, 2'b10, "R7 history cleared by cfg write");
    ev(4'd9, 2'd0, 2'b10, "R7 held high no recount");
    // edge without threshold is ignored
    wcfg(mk(0, 0, 2'd3, 0, 4'd5, 0, 1, 0, 0), "R12 cfg write");
    for (int e = 8; e < 12; e++) ev(4'(e), 2'd0, 2'b10, "R7 edge ignored without threshold");

    // R12: write cycle uses old config (raw add), next cycle new (threshold)
    cyc(4'd12, 2'd0, 2'b11, 1'b0, 1'b1, mk(0, 0, 2'd3, 1, 4'd1, 0, 0, 0, 0),
        1'b0, '0, "R12 write cycle counts under old config");
    ev(4'd12, 2'd0, 2'b11, "R12 new config next cycle");

    // R8: cascade counts partner pulses only
    wcfg(mk(0, 0, 2'd3, 0, 0, 0, 0, 1, 0), "R12 cfg write");
    for (int i = 0; i < 20; i++)
      cyc(4'd15, 2'd0, 2'b11, (i % 3) == 1, 1'b0, '0, 1'b0, '0, "R8 cascade input");

    // R10 / R11: wrap without interrupt enable
    wcfg(mk(0, 0, 2'd3, 0, 0, 0, 0, 0, 0), "R12 cfg write");
    wcnt({CNT_W{1'b1}} - 40'd3, "R9 load near top");
    ev(4'd2, 2'd0, 2'b11, "R10 below wrap");
    ev(4'd5, 2'd0, 2'b11, "R10 wrap pulse");
    ev(4'd1, 2'd0, 2'b11, "R10 pulse ends");
    ev(4'd0, 2'd0, 2'b11, "R11 no flag without enable");

    // R11: wrap with interrupt enable, flag sticky
    wcfg(mk(0, 0, 2'd3, 0, 0, 0, 0, 0, 1), "R12 cfg write");
    wcnt({CNT_W{1'b1}}, "R9 load all ones");
    ev(4'd1, 2'd0, 2'b11, "R11 wrap sets flag");
    for (int i = 0; i < 5; i++) ev(4'(i), 2'd0, 2'b11, "R11 flag sticky");
    wcnt(40'h12_3456_789A, "R11 write clears flag");

    // R9: write priority over increment and over wrap
    cyc(4'd15, 2'd0, 2'b11, 1'b0, 1'b0, '0, 1'b1, 40'hAB_CDEF_0123,
        "R9 write beats increment");
    wcnt({CNT_W{1'b1}}, "R9 load all ones");
    cyc(4'd15, 2'd0, 2'b11, 1'b0, 1'b0, '0, 1'b1, 40'd77, "R9 write suppresses wrap");
    ev(4'd4, 2'd0, 2'b11, "R9 counting resumes");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule